// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block buffers 18-bit words between two clock domains whose clocks need not be related in frequency or phase. A producer stores a word on each write-clock edge where its write strobe is high. A consumer takes words on the read clock. The two sides exchange their pointers in Gray code through two-flop synchronizers.

Two read behaviours are offered. The choice is made at master reset.

- **Explicit mode:** a word reaches the data output only when the consumer asks for it. The status outputs then mean "empty" and "full".
- **Fall-through mode:** the oldest word moves to the output register by itself. The status outputs then mean "output holds a valid word" and "room for another write".

Other functions:

- A half-full flag reports the state of the memory.
- An output enable floats the data bus.
- A partial reset discards the stored data but keeps the chosen mode.
- A retransmit pulse rewinds the read side to the first word written since the last reset, so the same data can be read a second time.

The almost-full and almost-empty thresholds are provided by a separate block, which reads the occupancy state of this one.

Top module: `dcf_modal_fifo`

## Requirements
- R1: A write-clock edge with `wen` high stores `din` when the memory holds fewer than DEPTH words. When the memory holds DEPTH words, the write is ignored and the stored contents stay unchanged.
- R2: Explicit mode:
  - A stored word is not driven onto `dout` until a read-clock edge with `ren` high loads it there.
  - Each such read loads the oldest unread word.
  - A read while no unread word is stored is ignored, and `dout` holds its value.
- R3: Explicit mode flags:
  - `empty_or` is 1 exactly when no unread word is stored.
  - `full_ir` is 1 exactly when the memory holds DEPTH words.
- R4: Fall-through mode:
  - The oldest word moves to `dout` with no read request, and `empty_or` (output valid) becomes 1.
  - A read-clock edge with `ren` high consumes that word and presents the next one, if there is one.
  - `full_ir` (input ready) is 1 while the memory holds fewer than DEPTH words. The word in the output register is not counted in the memory.
- R5: `half_full` is 1 exactly when the memory holds more than DEPTH/2 words.
- R6: The mode is taken from `mode_ft` (0 = explicit, 1 = fall-through) while `mrst_n` is low. Changes of `mode_ft` at any other time have no effect.
- R7: While `mrst_n` is low, both sides return to their reset state:
  - all data is discarded;
  - `dout` reads 0;
  - in explicit mode, `empty_or` is 1, and `full_ir` and `half_full` are 0.
- R8: A low `prst_n` discards all data and clears `dout` to 0, as master reset does, but keeps the selected mode.
- R9: A read-clock edge with `rt` high rewinds the read side to the first word written since the last reset:
  - in explicit mode, the next read returns that word;
  - in fall-through mode, that word reappears on `dout` without a read request.

  This is valid only when no more than DEPTH words have been written since that reset.
- R10: When `oe` is low, `dout` is high impedance.
- R11: Words leave in the order they were written, with the two clocks running at unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, sampled synchronously by both clocks; the mode is captured while it is low |
| prst_n | input | 1 | Partial reset, active low, sampled synchronously by both clocks; keeps the mode |
| mode_ft | input | 1 | Mode select: 1 = fall-through, 0 = explicit; used only during master reset |
| wen | input | 1 | Write enable |
| din | input | 18 | Write data |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request, one read-clock cycle |
| oe | input | 1 | Output enable; low floats `dout` |
| dout | output | 18 | Read data |
| full_ir | output | 1 | Explicit mode: full; fall-through mode: input ready |
| empty_or | output | 1 | Explicit mode: empty; fall-through mode: output valid |
| half_full | output | 1 | Memory holds more than DEPTH/2 words |

## Verification
The hardest situation to reach from the ports is fall-through mode with one word parked in the output register while the memory holds more words. The flags must then count only the memory. The stimulus builds this with random write bursts, lets both synchronizers settle, and then compares the flags with a model that subtracts the parked word.

The second hard case is a retransmit after every word has been consumed, which must make the first word reappear. It is reached by a partial reset that starts a fresh history, a few writes, a full drain, and an `rt` pulse. This is done in both modes.

A third hard case is writing into a full memory. It is reached by filling exactly DEPTH words, then draining them and checking that the rejected word never appears.

// File: rtl/dcf_pkg.sv
// Shared definitions for the dual-clock modal FIFO.
package dcf_pkg;
    // Read-side timing behaviour selected at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer, followed by Gray-to-binary
// conversion in the destination domain.
// Assumes the source changes its Gray value by at most one bit per source edge.
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Purpose: bring the foreign pointer into this clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Purpose: each binary bit is the parity of the Gray bits at and above it.
    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^sync_q[W-1:i];
    end
endmodule

// File: rtl/dcf_mem.sv
// Storage array: synchronous write on the write clock, combinational read.
// Assumes the controllers never write a slot that is still unread.
module dcf_mem #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Purpose: store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Purpose: present the word at the read pointer.
    assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wside.sv
// Write-side controller: write pointer, its Gray copy, occupancy, full and
// half-full. Occupancy uses the synchronized read pointer, so it is pessimistic
// by the synchronizer delay.
module dcf_wside
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mrst_n,
    input  logic          mode_in,
    input  logic          wen,
    input  logic [AW:0]   rbin_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic [AW:0]   cnt,
    output logic          full,
    output logic          hf,
    output rd_mode_e      mode
);
    localparam logic [AW:0] FULLV = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] HALFV = FULLV >> 1;

    logic [AW:0] wbin_nxt;

    // Purpose: capture the timing mode only during master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode <= rd_mode_e'(mode_in);
        end
    end

    // Purpose: derive occupancy, flags and the write strobe.
    always_comb begin
        cnt      = wbin - rbin_s;
        full     = (cnt == FULLV);
        hf       = (cnt > HALFV);
        we       = wen && !full;
        wbin_nxt = wbin + {{AW{1'b0}}, we};
    end

    // Purpose: advance the binary and registered Gray write pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/dcf_rside.sv
// Read-side controller: read pointer, output register, mode-dependent load
// rule and retransmit rewind.
// Explicit mode loads only on a read request. Fall-through mode refills the
// output register whenever it is free or being consumed.
// Retransmit rewinds to address zero, the slot of the first word after reset.
module dcf_rside
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mrst_n,
    input  logic          mode_in,
    input  logic          ren,
    input  logic          rt,
    input  logic [AW:0]   wbin_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout_q,
    output logic          ov,
    output logic          mem_empty,
    output rd_mode_e      mode
);
    logic        take;
    logic [AW:0] rbin_nxt;

    // Purpose: capture the timing mode only during master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode <= rd_mode_e'(mode_in);
        end
    end

    // Purpose: decide whether this edge moves a word into the output register.
    always_comb begin
        mem_empty = (rbin == wbin_s);
        if (mode == MODE_FWFT) begin
            take = !mem_empty && (!ov || ren) && !rt;
        end else begin
            take = !mem_empty && ren && !rt;
        end
        if (rt) begin
            rbin_nxt = '0;
        end else begin
            rbin_nxt = rbin + {{AW{1'b0}}, take};
        end
    end

    // Purpose: advance the read pointers and keep their Gray copy registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Purpose: load the output register and track its validity in fall-through mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            ov     <= 1'b0;
        end else begin
            if (take) begin
                dout_q <= rdata;
            end
            if (rt || mode != MODE_FWFT) begin
                ov <= 1'b0;
            end else if (take) begin
                ov <= 1'b1;
            end else if (ren) begin
                ov <= 1'b0;
            end
        end
    end

    assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/dcf_modal_fifo.sv
// Top level of the dual-clock FIFO with run-time selectable read timing.
// Assumes resets are held low for several edges of both clocks. Assumes rt is
// used only when no more than DEPTH words were written since the last reset,
// with writes idle until the rewound pointer has crossed domains.
module dcf_modal_fifo
    import dcf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_ft,
    input  logic          wen,
    input  logic [DW-1:0] din,
    input  logic          ren,
    input  logic          rt,
    input  logic          oe,
    output logic [DW-1:0] dout,
    output logic          full_ir,
    output logic          empty_or,
    output logic          half_full
);
    logic          dom_rst_n;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;
    logic [AW:0]   wbin;
    logic [AW:0]   wgray;
    logic [AW:0]   rbin;
    logic [AW:0]   rgray;
    logic [AW:0]   wbin_s;
    logic [AW:0]   rbin_s;
    logic [AW:0]   wcnt;
    logic          full;
    logic          hf;
    logic [DW-1:0] dout_q;
    logic          ov;
    logic          mem_empty;
    rd_mode_e      mode_w;
    rd_mode_e      mode_r;

    // Purpose: either reset empties both sides.
    assign dom_rst_n = mrst_n && prst_n;

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk (wclk),
        .we   (we),
        .waddr(waddr),
        .wdata(din),
        .raddr(raddr),
        .rdata(rdata)
    );

    dcf_wside #(.AW(AW)) u_wside (
        .clk    (wclk),
        .rst_n  (dom_rst_n),
        .mrst_n (mrst_n),
        .mode_in(mode_ft),
        .wen    (wen),
        .rbin_s (rbin_s),
        .we     (we),
        .waddr  (waddr),
        .wbin   (wbin),
        .wgray  (wgray),
        .cnt    (wcnt),
        .full   (full),
        .hf     (hf),
        .mode   (mode_w)
    );

    dcf_rside #(.AW(AW), .DW(DW)) u_rside (
        .clk      (rclk),
        .rst_n    (dom_rst_n),
        .mrst_n   (mrst_n),
        .mode_in  (mode_ft),
        .ren      (ren),
        .rt       (rt),
        .wbin_s   (wbin_s),
        .rdata    (rdata),
        .raddr    (raddr),
        .rbin     (rbin),
        .rgray    (rgray),
        .dout_q   (dout_q),
        .ov       (ov),
        .mem_empty(mem_empty),
        .mode     (mode_r)
    );

    dcf_sync #(.W(AW + 1)) u_w2r (
        .clk    (rclk),
        .rst_n  (dom_rst_n),
        .gray_in(wgray),
        .bin_out(wbin_s)
    );

    dcf_sync #(.W(AW + 1)) u_r2w (
        .clk    (wclk),
        .rst_n  (dom_rst_n),
        .gray_in(rgray),
        .bin_out(rbin_s)
    );

    // Purpose: map the internal state onto the mode-dependent flag meanings.
    assign full_ir   = (mode_w == MODE_FWFT) ? !full : full;
    assign empty_or  = (mode_r == MODE_FWFT) ? ov : mem_empty;
    assign half_full = hf;

    // Purpose: three-state data output.
    assign dout = oe ? dout_q : {DW{1'bz}};
endmodule

// File: rtl/dcf_checker.sv
// Property checker for dcf_modal_fifo, attached with bind.
module dcf_checker #(
    parameter int AW = 4
) (
    input logic        wclk,
    input logic        rclk,
    input logic        dom_rst_n,
    input logic        mrst_n,
    input logic        wen,
    input logic        ren,
    input logic        rt,
    input logic        full,
    input logic        hf,
    input logic [AW:0] wcnt,
    input logic [AW:0] wbin,
    input logic [AW:0] rbin,
    input logic        mem_empty,
    input logic        ov,
    input logic [17:0] dout_q,
    input logic        mode_w,
    input logic        mode_r
);
    localparam logic [AW:0] FULLV = {1'b1, {AW{1'b0}}};

    // R1: occupancy never passes the depth.
    p_count_bound_r1: assert property (@(posedge wclk) disable iff (!dom_rst_n)
        wcnt <= FULLV);

    // R1: a write into a full memory leaves the write pointer alone.
    p_full_write_ignored_r1: assert property (@(posedge wclk) disable iff (!dom_rst_n)
        full && wen |=> $stable(wbin));

    // R2: an explicit-mode read with nothing stored changes nothing.
    p_empty_read_ignored_r2: assert property (@(posedge rclk) disable iff (!dom_rst_n)
        !mode_r && mem_empty && ren && !rt |=> $stable(rbin) && $stable(dout_q));

    // R4: a valid fall-through word is held until consumed.
    p_ft_hold_r4: assert property (@(posedge rclk) disable iff (!dom_rst_n)
        mode_r && ov && !ren && !rt |=> ov && $stable(dout_q));

    // R5: a full memory is also above half.
    p_full_half_r5: assert property (@(posedge wclk) disable iff (!dom_rst_n)
        full |-> hf);

    // R6: the write-side mode holds while master reset stays released.
    p_mode_held_r6: assert property (@(posedge wclk) disable iff (!mrst_n)
        mrst_n |=> (!mrst_n || $stable(mode_w)));

    // R9: a retransmit request rewinds the read pointer to zero.
    p_rewind_r9: assert property (@(posedge rclk) disable iff (!dom_rst_n)
        rt |=> rbin == '0);
endmodule

bind dcf_modal_fifo dcf_checker #(.AW(AW)) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .dom_rst_n(dom_rst_n),
    .mrst_n   (mrst_n),
    .wen      (wen),
    .ren      (ren),
    .rt       (rt),
    .full     (full),
    .hf       (hf),
    .wcnt     (wcnt),
    .wbin     (wbin),
    .rbin     (rbin),
    .mem_empty(mem_empty),
    .ov       (ov),
    .dout_q   (dout_q),
    .mode_w   (mode_w),
    .mode_r   (mode_r)
);

// File: tb/test_dcf_modal_fifo.sv
// Self-checking bench: directed corner cases plus seeded random bursts, scored
// against a queue model of the stored words.
module test_dcf_modal_fifo;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        prst_n = 1'b1;
    logic        mode_ft = 1'b0;
    logic        wen = 1'b0;
    logic [17:0] din = '0;
    logic        ren = 1'b0;
    logic        rt = 1'b0;
    logic        oe = 1'b1;
    wire  [17:0] dout;
    wire         full_ir;
    wire         empty_or;
    wire         half_full;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;
    bit ft    = 1'b0;
    logic [17:0] mq[$];
    logic [17:0] hist[$];
    logic [17:0] last = '0;

    always #5 wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    dcf_modal_fifo #(.DW(18), .AW(AW)) i_dcf_modal_fifo (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_ft(mode_ft), .wen(wen), .din(din), .ren(ren), .rt(rt), .oe(oe),
        .dout(dout), .full_ir(full_ir), .empty_or(empty_or), .half_full(half_full)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge rclk);
        repeat (4) @(posedge wclk);
        @(negedge rclk);
    endtask

    task automatic do_mrst(input bit sel);
        @(negedge wclk);
        mrst_n  = 1'b0;
        mode_ft = sel;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        mrst_n = 1'b1;
        ft = sel;
        mq.delete(); hist.delete(); last = '0;
        settle();
    endtask

    task automatic do_prst();
        @(negedge wclk);
        prst_n = 1'b0;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        prst_n = 1'b1;
        mq.delete(); hist.delete(); last = '0;
        settle();
    endtask

    task automatic wr(input logic [17:0] w, input bit acc);
        @(negedge wclk);
        wen = 1'b1;
        din = w;
        @(negedge wclk);
        wen = 1'b0;
        if (acc) begin
            mq.push_back(w);
            hist.push_back(w);
        end
    endtask

    // Explicit-mode read followed by a check of the loaded word.
    task automatic rd_std(input string req);
        logic [17:0] e;
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        if (mq.size() > 0) e = mq.pop_front();
        else e = last;
        last = e;
        chk(req, "explicit read data", 32'(dout), 32'(e));
    endtask

    // Fall-through read: the head word must already be visible.
    task automatic rd_ft(input string req);
        chk(req, "fall-through head", 32'(dout), 32'(mq[0]));
        chk(req, "output valid", 32'(empty_or), 32'd1);
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        last = mq.pop_front();
    endtask

    task automatic pulse_rt();
        @(negedge rclk);
        rt = 1'b1;
        @(negedge rclk);
        rt = 1'b0;
        mq = hist;
    endtask

    function automatic int mem_occ(input bit f, input int n);
        if (f) return (n > 0) ? n - 1 : 0;
        return n;
    endfunction

    task automatic chk_flags(input string req);
        int n;
        int m;
        n = mq.size();
        m = mem_occ(ft, n);
        chk(req, "empty_or", 32'(empty_or), ft ? 32'(n > 0) : 32'(n == 0));
        chk(req, "full_ir", 32'(full_ir), ft ? 32'(m < DEPTH) : 32'(m == DEPTH));
        chk("R5", "half_full", 32'(half_full), 32'(m > DEPTH / 2));
    endtask

    task automatic random_rounds(input int rounds);
        for (int k = 0; k < rounds; k++) begin
            int nw;
            int nr;
            nw = $urandom_range(DEPTH - mq.size(), 0);
            for (int i = 0; i < nw; i++) wr(18'($urandom), 1'b1);
            settle();
            chk_flags("R11");
            nr = $urandom_range(mq.size(), 0);
            for (int i = 0; i < nr; i++) begin
                if (ft) rd_ft("R11");
                else rd_std("R11");
            end
            settle();
            chk_flags("R11");
        end
    endtask

    initial begin
        void'($urandom(32'd4242));

        // R7: master reset state in explicit mode.
        do_mrst(1'b0);
        chk("R7", "empty after reset", 32'(empty_or), 32'd1);
        chk("R7", "not full after reset", 32'(full_ir), 32'd0);
        chk("R7", "half clear after reset", 32'(half_full), 32'd0);
        chk("R7", "dout zero after reset", 32'(dout), 32'd0);

        // R2, R3: an explicit-mode word waits for a read.
        wr(18'h2A5A5, 1'b1);
        settle();
        chk("R2", "no word before read", 32'(dout), 32'd0);
        chk("R3", "not empty with a word", 32'(empty_or), 32'd0);
        rd_std("R2");
        settle();
        chk("R3", "empty after drain", 32'(empty_or), 32'd1);
        rd_std("R2");

        // R10: output enable floats the bus.
        oe = 1'b0;
        #1;
        chk("R10", "dout floating", 32'(dout === 18'bz), 32'd1);
        oe = 1'b1;
        #1;
        chk("R10", "dout driven again", 32'(dout), 32'(last));

        // R5, R3, R1: half-full edge, full, and a rejected write.
        for (int i = 0; i < DEPTH / 2; i++) wr(18'(16'h100 + i), 1'b1);
        settle();
        chk("R5", "at half not flagged", 32'(half_full), 32'd0);
        wr(18'h00777, 1'b1);
        settle();
        chk("R5", "above half flagged", 32'(half_full), 32'd1);
        for (int i = DEPTH / 2 + 1; i < DEPTH; i++) wr(18'(16'h200 + i), 1'b1);
        settle();
        chk("R3", "full at depth", 32'(full_ir), 32'd1);
        wr(18'h3DEAD, 1'b0);
        settle();
        for (int i = 0; i < DEPTH; i++) rd_std("R1");
        settle();
        chk("R1", "rejected word absent", 32'(empty_or), 32'd1);

        // R6: a mode change outside master reset is ignored.
        mode_ft = 1'b1;
        settle();
        chk("R6", "still explicit full flag", 32'(full_ir), 32'd0);
        wr(18'h01234, 1'b1);
        settle();
        chk("R6", "no fall-through", 32'(dout), 32'(last));

        // R9, R8: retransmit in explicit mode after a partial reset.
        do_prst();
        chk("R8", "partial reset empties", 32'(empty_or), 32'd1);
        chk("R8", "partial reset clears dout", 32'(dout), 32'd0);
        wr(18'h0AAAA, 1'b1);
        wr(18'h0BBBB, 1'b1);
        wr(18'h0CCCC, 1'b1);
        settle();
        for (int i = 0; i < 3; i++) rd_std("R9");
        pulse_rt();
        settle();
        chk("R9", "data again after rewind", 32'(empty_or), 32'd0);
        rd_std("R9");

        // R6, R4: fall-through mode chosen at master reset.
        do_mrst(1'b1);
        chk("R6", "input ready in fall-through", 32'(full_ir), 32'd1);
        chk("R4", "no output valid yet", 32'(empty_or), 32'd0);
        wr(18'h15555, 1'b1);
        settle();
        chk("R4", "word fell through", 32'(dout), 32'h15555);
        chk("R4", "output valid", 32'(empty_or), 32'd1);
        rd_ft("R4");
        settle();
        chk("R4", "output valid cleared", 32'(empty_or), 32'd0);

        // R8: partial reset keeps fall-through mode.
        wr(18'h00011, 1'b1);
        wr(18'h00022, 1'b1);
        do_prst();
        chk("R8", "no valid after partial reset", 32'(empty_or), 32'd0);
        chk("R8", "mode kept: input ready", 32'(full_ir), 32'd1);
        wr(18'h0C0DE, 1'b1);
        settle();
        chk("R8", "still falls through", 32'(dout), 32'h0C0DE);

        // R9: retransmit in fall-through mode.
        wr(18'h0D00D, 1'b1);
        wr(18'h0E00E, 1'b1);
        settle();
        for (int i = 0; i < 3; i++) rd_ft("R9");
        settle();
        chk("R9", "drained", 32'(empty_or), 32'd0);
        pulse_rt();
        settle();
        chk("R9", "first word reappears", 32'(dout), 32'h0C0DE);
        chk("R9", "valid after rewind", 32'(empty_or), 32'd1);

        // R11: random bursts in both modes.
        do_mrst(1'b0);
        random_rounds(15);
        do_mrst(1'b1);
        random_rounds(15);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule